// File: doc/BRIEF.md
# Eight-Input Cascadable Interrupt Controller

This block collects eight interrupt request lines and turns them into a single interrupt output and a vector byte. Software reaches it through a byte bus with two addresses: a command address (bus_addr = 0) and a data address (bus_addr = 1). It keeps three byte-wide registers: pending requests, requests in service and a mask. It is brought up by a fixed sequence of configuration writes. Specific end-of-interrupt commands and read-back selection use command bytes.

Several controllers can be chained. A master marks the inputs that have a second controller behind them. When such an input wins an acknowledge, the master reports which input it was and leaves the vector to the second controller. A controller strapped as secondary answers an acknowledge only when the cascade identity presented to it matches its own.

The vector leaves as a one-cycle `vec_valid` pulse with no ready signal. The acknowledge strobe is the consumer's request, so it cannot push back. The bus, the interrupt output and the cascade pins are plain control signals.

Top module: `pic_intc`

## Requirements
- R1: After reset the mask reads 0xFF, the pending and in-service registers are clear, the command address returns the pending register, and until a configuration sequence completes no request line can set a pending bit or raise int_out.
- R2: A command write with bit 4 set clears the pending and in-service registers and starts configuration. Bit 3 of that byte selects level-sensitive inputs (1) or edge-sensitive inputs (0). The next three data writes are taken as vector base, cascade word and mode word, in that order, and do not change the mask. The mask keeps its value across configuration.
- R3: An acknowledge that grants input n produces vec_valid high for exactly the cycle after the strobe, with vec_data = base + n (8-bit sum).
- R4: Priority is fixed, with input 0 highest. int_out is high exactly when some unmasked pending bit has a lower index than every set in-service bit.
- R5: In edge mode a rising edge on a line sets its pending bit, and the bit stays set after the line falls until that input is granted. In level mode the pending bit follows the line.
- R6: An acknowledge moves the winning pending bit into the in-service register.
- R7: When bit 1 of the mode word is set (auto end-of-interrupt), a grant leaves the in-service register unchanged.
- R8: A command byte 0x60 + n clears in-service bit n and no other bit.
- R9: Command byte 0x0A selects the pending register and 0x0B selects the in-service register for command-address reads. The choice holds for any number of reads until another select byte or a new configuration start.
- R10: Outside configuration, data-address writes and reads access the mask. A set mask bit still lets its pending bit be captured, but keeps that input out of int_out and the grant.
- R11: An acknowledge with no eligible request gives vec_data = base + 7 and leaves the in-service register unchanged. This happens whatever mask bit 7 holds.
- R12: On a master, if the granted input has its bit set in the cascade word, the next cycle shows cas_active high with cas_id_out = n and vec_valid low. The in-service bit is set as for any grant.
- R13: With slave_mode high, an acknowledge is taken only when cas_id_in equals bits 2:0 of the cascade word. Otherwise it produces no vector and changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Byte write strobe |
| bus_addr | input | 1 | 0 = command address, 1 = data address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| irq_in | input | 8 | Request lines, bit n = input n |
| int_out | output | 1 | Interrupt request to the processor |
| int_ack | input | 1 | One-cycle acknowledge strobe |
| slave_mode | input | 1 | Strap: 1 = secondary in a cascade |
| cas_id_in | input | 3 | Cascade identity presented to a secondary |
| vec_valid | output | 1 | One-cycle vector strobe |
| vec_data | output | 8 | Vector byte |
| cas_active | output | 1 | Master: the vector comes from the secondary on cas_id_out |
| cas_id_out | output | 3 | Master: granted cascade input |

## Verification
The bench goes after nested service. A lower-priority request must wait behind a set in-service bit and reappear after the matching specific end-of-interrupt; a design that compared priorities wrongly would raise int_out too early or never. It drops a level-mode request before the acknowledge, with input 7 masked, to show that the spurious vector is still base + 7 and that no in-service bit appears. It also checks that an edge-mode bit outlives its line and that a set mask hides a captured request without discarding it. A cascade grant must not emit a vector, and a secondary must ignore a mismatched identity, so any leak of vec_valid or any register change in those cases is reported.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int PIC_LINES  = 8;
  localparam int PIC_IDX_W  = $clog2(PIC_LINES);
  localparam int PIC_BYTE_W = 8;

  typedef logic [PIC_LINES-1:0]  line_vec_t;
  typedef logic [PIC_IDX_W-1:0]  line_idx_t;
  typedef logic [PIC_BYTE_W-1:0] byte_t;

  typedef enum logic [1:0] {
    SEQ_IDLE,
    SEQ_BASE,
    SEQ_CASC,
    SEQ_MODE
  } seq_state_t;

  localparam byte_t CMD_SEL_IRR  = 8'h0A;
  localparam byte_t CMD_SEL_ISR  = 8'h0B;
  localparam logic [4:0] EOI_PREFIX = 5'b01100;
  localparam int START_BIT = 4;
  localparam int LEVEL_BIT = 3;
  localparam int AEOI_BIT  = 1;
endpackage

// File: rtl/pic_cfg_regs.sv
module pic_cfg_regs
  import pic_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wr_en,
  input  logic      wr_addr,
  input  byte_t     wr_data,
  output byte_t     vec_base,
  output byte_t     casc_word,
  output byte_t     imr,
  output logic      aeoi,
  output logic      level_mode,
  output logic      sel_isr,
  output logic      cfg_done,
  output logic      init_pulse,
  output logic      eoi_pulse,
  output line_idx_t eoi_idx
);
  seq_state_t seq_q;
  logic cmd_wr, data_wr, is_start, is_eoi;

  always_comb begin
    cmd_wr     = wr_en & ~wr_addr;
    data_wr    = wr_en & wr_addr;
    is_start   = wr_data[START_BIT];
    is_eoi     = (wr_data[7:3] == EOI_PREFIX);
    init_pulse = cmd_wr & is_start;
    eoi_pulse  = cmd_wr & ~is_start & is_eoi;
    eoi_idx    = wr_data[PIC_IDX_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seq_q      <= SEQ_IDLE;
      vec_base   <= '0;
      casc_word  <= '0;
      imr        <= '1;
      aeoi       <= 1'b0;
      level_mode <= 1'b0;
      sel_isr    <= 1'b0;
      cfg_done   <= 1'b0;
    end else begin
      if (init_pulse) begin
        seq_q      <= SEQ_BASE;
        cfg_done   <= 1'b0;
        sel_isr    <= 1'b0;
        level_mode <= wr_data[LEVEL_BIT];
      end else if (cmd_wr && wr_data == CMD_SEL_IRR) begin
        sel_isr <= 1'b0;
      end else if (cmd_wr && wr_data == CMD_SEL_ISR) begin
        sel_isr <= 1'b1;
      end
      if (data_wr) begin
        case (seq_q)
          SEQ_IDLE: imr <= wr_data;
          SEQ_BASE: begin
            vec_base <= wr_data;
            seq_q    <= SEQ_CASC;
          end
          SEQ_CASC: begin
            casc_word <= wr_data;
            seq_q     <= SEQ_MODE;
          end
          SEQ_MODE: begin
            aeoi     <= wr_data[AEOI_BIT];
            cfg_done <= 1'b1;
            seq_q    <= SEQ_IDLE;
          end
          default: seq_q <= SEQ_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/pic_req_latch.sv
module pic_req_latch
  import pic_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  line_vec_t irq_in,
  input  logic      level_mode,
  input  logic      enable,
  input  logic      clear_all,
  input  logic      grant,
  input  line_idx_t grant_idx,
  output line_vec_t irr
);
  for (genvar g = 0; g < PIC_LINES; g++) begin : g_line
    logic prev_q, irr_q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        prev_q <= 1'b0;
        irr_q  <= 1'b0;
      end else begin
        prev_q <= irq_in[g];
        if (clear_all || !enable)
          irr_q <= 1'b0;
        else if (level_mode)
          irr_q <= irq_in[g];
        else if (irq_in[g] && !prev_q)
          irr_q <= 1'b1;
        else if (grant && grant_idx == line_idx_t'(g))
          irr_q <= 1'b0;
      end
    end
    assign irr[g] = irr_q;
  end
endmodule

// File: rtl/pic_prio_res.sv
module pic_prio_res
  import pic_pkg::*;
(
  input  line_vec_t irr,
  input  line_vec_t isr,
  input  line_vec_t imr,
  input  logic      enable,
  output logic      win_valid,
  output line_idx_t win_idx,
  output logic      int_req
);
  line_vec_t isr_pfx, cand;
  logic acc;

  always_comb begin
    acc = 1'b0;
    for (int i = 0; i < PIC_LINES; i++) begin
      acc        = acc | isr[i];
      isr_pfx[i] = acc;
    end
    cand      = irr & ~imr & ~isr_pfx & {PIC_LINES{enable}};
    win_valid = |cand;
    win_idx   = '0;
    for (int i = PIC_LINES - 1; i >= 0; i--) begin
      if (cand[i]) win_idx = line_idx_t'(i);
    end
    int_req = win_valid;
  end
endmodule

// File: rtl/pic_intc.sv
module pic_intc
  import pic_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_wr,
  input  logic       bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic [7:0] irq_in,
  output logic       int_out,
  input  logic       int_ack,
  input  logic       slave_mode,
  input  logic [2:0] cas_id_in,
  output logic       vec_valid,
  output logic [7:0] vec_data,
  output logic       cas_active,
  output logic [2:0] cas_id_out
);
  byte_t     vec_base, casc_word, imr;
  logic      aeoi, level_mode, sel_isr, cfg_done, init_pulse, eoi_pulse;
  line_idx_t eoi_idx, win_idx;
  line_vec_t irr, isr, isr_set, isr_clr;
  logic      win_valid, int_req, ack_take, grant, casc_hit;

  pic_cfg_regs u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .wr_addr(bus_addr),
    .wr_data(bus_wdata), .vec_base(vec_base), .casc_word(casc_word),
    .imr(imr), .aeoi(aeoi), .level_mode(level_mode), .sel_isr(sel_isr),
    .cfg_done(cfg_done), .init_pulse(init_pulse), .eoi_pulse(eoi_pulse),
    .eoi_idx(eoi_idx)
  );

  pic_req_latch u_req (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .level_mode(level_mode),
    .enable(cfg_done), .clear_all(init_pulse), .grant(grant),
    .grant_idx(win_idx), .irr(irr)
  );

  pic_prio_res u_prio (
    .irr(irr), .isr(isr), .imr(imr), .enable(cfg_done),
    .win_valid(win_valid), .win_idx(win_idx), .int_req(int_req)
  );

  always_comb begin
    ack_take = int_ack & cfg_done &
               (~slave_mode | (cas_id_in == casc_word[PIC_IDX_W-1:0]));
    grant    = ack_take & win_valid;
    casc_hit = ~slave_mode & casc_word[win_idx];
    isr_set  = '0;
    isr_clr  = '0;
    if (grant && !aeoi) isr_set[win_idx] = 1'b1;
    if (eoi_pulse)      isr_clr[eoi_idx] = 1'b1;
    int_out   = int_req;
    bus_rdata = bus_addr ? imr : (sel_isr ? isr : irr);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      isr        <= '0;
      vec_valid  <= 1'b0;
      vec_data   <= '0;
      cas_active <= 1'b0;
      cas_id_out <= '0;
    end else begin
      if (init_pulse) isr <= '0;
      else            isr <= (isr & ~isr_clr) | isr_set;
      vec_valid  <= ack_take & ~(grant & casc_hit);
      cas_active <= grant & casc_hit;
      if (ack_take) begin
        vec_data   <= vec_base + byte_t'(grant ? win_idx : line_idx_t'(PIC_LINES - 1));
        cas_id_out <= win_idx;
      end
    end
  end
endmodule

// File: rtl/pic_intc_chk.sv
module pic_intc_chk
  import pic_pkg::*;
(
  input logic      clk,
  input logic      rst_n,
  input logic      int_ack,
  input logic      int_out,
  input logic      vec_valid,
  input logic      cas_active,
  input logic      cfg_done,
  input logic      aeoi,
  input byte_t     imr,
  input line_vec_t isr,
  input line_vec_t irr,
  input logic      slave_mode,
  input line_idx_t cas_id_in,
  input byte_t     casc_word
);
  p_vec_after_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> $past(int_ack));

  p_no_int_unconfigured_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_done |-> (!int_out && irr == '0));

  p_full_mask_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (imr == 8'hFF) |-> !int_out);

  p_cascade_no_vec_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !(vec_valid && cas_active));

  p_auto_eoi_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_done && aeoi) |-> (isr == '0));

  p_slave_mismatch_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (int_ack && slave_mode && cas_id_in != casc_word[PIC_IDX_W-1:0])
      |=> (!vec_valid && $stable(isr)));
endmodule

bind pic_intc pic_intc_chk u_chk (
  .clk(clk), .rst_n(rst_n), .int_ack(int_ack), .int_out(int_out),
  .vec_valid(vec_valid), .cas_active(cas_active), .cfg_done(cfg_done),
  .aeoi(aeoi), .imr(imr), .isr(isr), .irr(irr), .slave_mode(slave_mode),
  .cas_id_in(cas_id_in), .casc_word(casc_word)
);

// File: tb/pic_intc_test.sv
`timescale 1ns/1ps
module pic_intc_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0;
  logic       bus_addr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [7:0] irq_in = '0;
  logic       int_out;
  logic       int_ack = 1'b0;
  logic       slave_mode = 1'b0;
  logic [2:0] cas_id_in = '0;
  logic       vec_valid;
  logic [7:0] vec_data;
  logic       cas_active;
  logic [2:0] cas_id_out;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  pic_intc uut (.*);

  always #2.5 clk = ~clk;

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] v);
    bus_addr = a;
    #1;
    v = bus_rdata;
  endtask

  task automatic drive_irq(input logic [7:0] v);
    @(negedge clk);
    irq_in = v;
    @(negedge clk);
  endtask

  task automatic ack(input logic [2:0] id);
    @(negedge clk);
    cas_id_in = id; int_ack = 1'b1;
    @(negedge clk);
    int_ack = 1'b0;
  endtask

  task automatic configure(input logic [7:0] w1, input logic [7:0] b,
                           input logic [7:0] c, input logic [7:0] m);
    wr(1'b0, w1); wr(1'b1, b); wr(1'b1, c); wr(1'b1, m);
  endtask

  task automatic t_reset;
    logic [7:0] v;
    rd(1'b1, v); chk("R1 mask after reset", v, 8'hFF);
    rd(1'b0, v); chk("R1 pending after reset", v, 8'h00);
    chk("R1 int_out after reset", {7'b0, int_out}, 8'h00);
    wr(1'b1, 8'h00);
    drive_irq(8'h01);
    chk("R1 int_out before configuration", {7'b0, int_out}, 8'h00);
    rd(1'b0, v); chk("R1 pending before configuration", v, 8'h00);
    drive_irq(8'h00);
  endtask

  task automatic t_config;
    logic [7:0] v;
    configure(8'h11, 8'h20, 8'h04, 8'h01);
    rd(1'b1, v); chk("R2 mask untouched by configuration", v, 8'h00);
  endtask

  task automatic t_nesting;
    logic [7:0] v;
    drive_irq(8'h28);
    rd(1'b0, v); chk("R5 edges captured", v, 8'h28);
    chk("R4 int_out with pending", {7'b0, int_out}, 8'h01);
    ack(3'd0);
    chk("R3 vec_valid", {7'b0, vec_valid}, 8'h01);
    chk("R3 R4 vector input 3", vec_data, 8'h23);
    @(negedge clk);
    chk("R3 vec_valid single cycle", {7'b0, vec_valid}, 8'h00);
    drive_irq(8'h00);
    rd(1'b0, v); chk("R5 R6 pending kept after line falls", v, 8'h20);
    chk("R4 blocked by in-service", {7'b0, int_out}, 8'h00);
    wr(1'b0, 8'h0B);
    rd(1'b0, v); chk("R6 in-service", v, 8'h08);
    rd(1'b0, v); chk("R9 selection holds", v, 8'h08);
    drive_irq(8'h02);
    chk("R4 higher priority nests", {7'b0, int_out}, 8'h01);
    ack(3'd0);
    chk("R3 vector input 1", vec_data, 8'h21);
    drive_irq(8'h00);
    rd(1'b0, v); chk("R6 nested in-service", v, 8'h0A);
    wr(1'b0, 8'h61);
    rd(1'b0, v); chk("R8 clears only bit 1", v, 8'h08);
    chk("R4 still blocked", {7'b0, int_out}, 8'h00);
    wr(1'b0, 8'h63);
    chk("R4 released after eoi", {7'b0, int_out}, 8'h01);
    ack(3'd0);
    chk("R3 vector input 5", vec_data, 8'h25);
    wr(1'b0, 8'h65);
    rd(1'b0, v); chk("R8 in-service empty", v, 8'h00);
    wr(1'b0, 8'h0A);
    rd(1'b0, v); chk("R9 pending selected again", v, 8'h00);
  endtask

  task automatic t_mask;
    logic [7:0] v;
    wr(1'b1, 8'hFF);
    rd(1'b1, v); chk("R10 mask read", v, 8'hFF);
    drive_irq(8'h10);
    drive_irq(8'h00);
    rd(1'b0, v); chk("R10 masked request captured", v, 8'h10);
    chk("R10 masked int_out", {7'b0, int_out}, 8'h00);
    wr(1'b1, 8'hEF);
    chk("R10 unmask raises int_out", {7'b0, int_out}, 8'h01);
    ack(3'd0);
    chk("R10 vector after unmask", vec_data, 8'h24);
    wr(1'b0, 8'h64);
    wr(1'b1, 8'h00);
  endtask

  task automatic t_cascade;
    logic [7:0] v;
    drive_irq(8'h04);
    drive_irq(8'h00);
    ack(3'd0);
    chk("R12 no vector from master", {7'b0, vec_valid}, 8'h00);
    chk("R12 cas_active", {7'b0, cas_active}, 8'h01);
    chk("R12 cas_id_out", {5'b0, cas_id_out}, 8'h02);
    wr(1'b0, 8'h0B);
    rd(1'b0, v); chk("R12 in-service set", v, 8'h04);
    wr(1'b0, 8'h62);
    wr(1'b0, 8'h0A);
  endtask

  task automatic t_auto_eoi;
    logic [7:0] v;
    configure(8'h11, 8'h40, 8'h04, 8'h03);
    drive_irq(8'h40);
    drive_irq(8'h00);
    ack(3'd0);
    chk("R7 vector", vec_data, 8'h46);
    chk("R7 int_out cleared", {7'b0, int_out}, 8'h00);
    wr(1'b0, 8'h0B);
    rd(1'b0, v); chk("R7 in-service untouched", v, 8'h00);
  endtask

  task automatic t_spurious;
    logic [7:0] v;
    configure(8'h19, 8'h30, 8'h04, 8'h01);
    wr(1'b1, 8'h80);
    drive_irq(8'h08);
    rd(1'b0, v); chk("R5 level pending", v, 8'h08);
    chk("R2 level int_out", {7'b0, int_out}, 8'h01);
    drive_irq(8'h00);
    rd(1'b0, v); chk("R5 level follows line", v, 8'h00);
    ack(3'd0);
    chk("R11 spurious vec_valid", {7'b0, vec_valid}, 8'h01);
    chk("R11 spurious vector", vec_data, 8'h37);
    wr(1'b0, 8'h0B);
    rd(1'b0, v); chk("R11 in-service unchanged", v, 8'h00);
  endtask

  task automatic t_slave;
    logic [7:0] v;
    slave_mode = 1'b1;
    configure(8'h11, 8'h70, 8'h02, 8'h01);
    wr(1'b1, 8'h00);
    drive_irq(8'h10);
    drive_irq(8'h00);
    ack(3'd5);
    chk("R13 mismatched id no vector", {7'b0, vec_valid}, 8'h00);
    rd(1'b0, v); chk("R13 pending kept", v, 8'h10);
    ack(3'd2);
    chk("R13 matched id vec_valid", {7'b0, vec_valid}, 8'h01);
    chk("R13 matched id vector", vec_data, 8'h74);
    wr(1'b0, 8'h0B);
    rd(1'b0, v); chk("R13 in-service after match", v, 8'h10);
    slave_mode = 1'b0;
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_config;
    t_nesting;
    t_mask;
    t_cascade;
    t_auto_eoi;
    t_spurious;
    t_slave;
    finish_run;
  end

  initial begin
    #(200000 * 5);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run;
  end
endmodule